// File: doc/BRIEF.md
# Port Power Sequencer

This block controls one power-over-Ethernet port. Firmware picks one of four modes. The block then drives the port through detection, classification and power-up. It starts the external detection and classification engines with one-cycle strobes. It collects their done/valid answers and drives the enable for the external power switch gate. It keeps a small set of sticky completion flags and result flags for the port.

In automatic mode the port runs by itself. It keeps detecting until a device answers with a valid signature, then classifies it and powers it. In semi-automatic mode, detection and classification repeat while enabled, but only an explicit power-on command applies power. In manual mode each enable bit is a one-shot command. Shutdown mode removes power at once and ignores every command.

The two enable bits are therefore persistent settings in two modes and self-clearing buttons in a third. A power-on command overrides whatever is running. Time windows are given in milliseconds and scaled by the clock rate.

Top module: `poe_port_seq`

## Requirements
- R1: After reset, `mode_o` reads 00 (shutdown), the gate enable and both start strobes are low, and both enable bits read 0.
- R2: Mode code 11 (automatic) sets both enable bits on entry. A valid detection result is followed by a classification strobe. When classification finishes, the gate enable rises.
- R3: In automatic mode with the detection enable at 0, the port stays unpowered and issues no strobe. This holds until the bypass input is high, after which the port powers up directly.
- R4: When the midspan strap is low, an invalid detection result in automatic mode returns to idle. The next detection strobe follows one cycle later.
- R5: When the midspan strap is high, the first detection starts right away. After an invalid result the next strobe is delayed by MID_WAIT_MS × CLK_KHZ cycles. From the cycle that takes the result to the visible strobe, the count is that value plus one.
- R6: Mode code 10 (semi-automatic) clears both enable bits on entry. While enabled, detection and classification repeat, and the gate never rises without a power-on command.
- R7: In semi-automatic mode, a power-off command drops power and clears both enable bits. A power drop requested by the disconnect/fault input leaves the enable bits unchanged.
- R8: Mode code 01 (manual) clears both enable bits on entry. Each enable bit clears when its task ends. With both set, the detection strobe comes before the classification strobe, and nothing repeats afterwards.
- R9: In manual mode with the port powered, writes to the enable bits are ignored.
- R10: In any mode other than shutdown, a power-on command aborts a running task. The gate enable is high in the next cycle.
- R11: Code 00 (shutdown) drops the gate in the next cycle. It clears the enable bits and all completion and result flags, and it ignores power-on and enable writes.
- R12: A change among the three non-shutdown modes takes effect only after a running detection or classification task has ended.
- R13: If classification does not report done within CLS_WIN_MS × CLK_KHZ cycles, the cycle ends at that count with a failed classification result.
- R14: The completion flags are set when a task ends, and the result flags hold its outcome. All four flags clear when the port leaves the powered state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Requested mode: 11 auto, 10 semi, 01 manual, 00 shutdown |
| en_wr_i | input | 1 | Write strobe for the two enable bits |
| det_en_d_i | input | 1 | Detection enable value to write |
| cls_en_d_i | input | 1 | Classification enable value to write |
| pwr_on_i | input | 1 | Power-on command pulse |
| pwr_off_i | input | 1 | Power-off command pulse |
| drop_i | input | 1 | Disconnect/fault power drop request |
| det_byp_i | input | 1 | Allow power-up in automatic mode without detection |
| midspan_i | input | 1 | Midspan strap, adds back-off after failed detection |
| det_done_i | input | 1 | Detection engine finished |
| det_valid_i | input | 1 | Detection found a valid signature |
| cls_done_i | input | 1 | Classification engine finished |
| cls_valid_i | input | 1 | Classification result is valid |
| mode_o | output | 2 | Mode currently in effect |
| det_en_o | output | 1 | Detection enable bit |
| cls_en_o | output | 1 | Classification enable bit |
| det_start_o | output | 1 | One-cycle detection start strobe |
| cls_start_o | output | 1 | One-cycle classification start strobe |
| gate_en_o | output | 1 | Port power switch gate enable |
| det_end_o | output | 1 | Sticky detection-completed flag |
| cls_end_o | output | 1 | Sticky classification-completed flag |
| det_ok_o | output | 1 | Result of the last detection |
| cls_ok_o | output | 1 | Result of the last classification |

## Verification
One directed sequence walks the port through every mode in turn, using a small clock rate so the windows are a few cycles long.

- Valid and invalid detection answers are given with the strap both low and high. This separates the immediate retry from the back-off, whose length is counted to the cycle.
- Both enables set together in manual mode tell the one-shot order apart from the repeating semi-automatic loop.
- Withholding the classification answer exposes the window boundary one cycle before and at expiry.
- Power-on, power-off and fault drops are issued in several states. This shows which of them clear the enable bits and which leave them alone.

// File: rtl/poe_seq_pkg.sv
`timescale 1ns/1ps
package poe_seq_pkg;
  typedef enum logic [1:0] {
    MODE_SHUT = 2'b00,
    MODE_MAN  = 2'b01,
    MODE_SEMI = 2'b10,
    MODE_AUTO = 2'b11
  } port_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DET,
    ST_WAIT,
    ST_CLS,
    ST_PWR
  } seq_state_e;
endpackage

// File: rtl/poe_seq_timer.sv
`timescale 1ns/1ps
module poe_seq_timer #(
  parameter int unsigned LEN = 40000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic exp_o
);
  localparam int unsigned W = (LEN < 2) ? 1 : $clog2(LEN + 1);

  logic [W-1:0] cnt_q;

  assign exp_o = run_i && (cnt_q == W'(LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (!exp_o) cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/poe_seq_mode.sv
`timescale 1ns/1ps
module poe_seq_mode
  import poe_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  port_mode_e req_i,
  input  logic       busy_i,
  output port_mode_e mode_o,
  output logic       shut_o,
  output logic       enter_o
);
  port_mode_e mode_q;

  assign shut_o  = (req_i == MODE_SHUT);
  // non-shutdown switches wait for a running task to end
  assign enter_o = !shut_o && (req_i != mode_q) && !busy_i;
  assign mode_o  = mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mode_q <= MODE_SHUT;
    else if (shut_o)  mode_q <= MODE_SHUT;
    else if (enter_o) mode_q <= req_i;
  end
endmodule

// File: rtl/poe_seq_enables.sv
`timescale 1ns/1ps
module poe_seq_enables
  import poe_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  port_mode_e mode_i,
  input  port_mode_e new_mode_i,
  input  logic       enter_i,
  input  logic       shut_i,
  input  logic       powered_i,
  input  logic       wr_i,
  input  logic       det_d_i,
  input  logic       cls_d_i,
  input  logic       det_clr_i,
  input  logic       cls_clr_i,
  input  logic       off_clr_i,
  output logic       det_en_o,
  output logic       cls_en_o
);
  logic det_q, cls_q;
  logic wr_ok;

  assign wr_ok    = wr_i && !(mode_i == MODE_MAN && powered_i);
  assign det_en_o = det_q;
  assign cls_en_o = cls_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      det_q <= 1'b0;
      cls_q <= 1'b0;
    end else if (shut_i) begin
      det_q <= 1'b0;
      cls_q <= 1'b0;
    end else if (enter_i) begin
      det_q <= (new_mode_i == MODE_AUTO);
      cls_q <= (new_mode_i == MODE_AUTO);
    end else begin
      if (det_clr_i || off_clr_i) det_q <= 1'b0;
      if (cls_clr_i || off_clr_i) cls_q <= 1'b0;
      if (wr_ok) begin
        det_q <= det_d_i;
        cls_q <= cls_d_i;
      end
    end
  end
endmodule

// File: rtl/poe_seq_fsm.sv
`timescale 1ns/1ps
module poe_seq_fsm
  import poe_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  port_mode_e mode_i,
  input  logic       shut_i,
  input  logic       sw_i,
  input  logic       pwr_on_i,
  input  logic       pwr_off_i,
  input  logic       drop_i,
  input  logic       det_en_i,
  input  logic       cls_en_i,
  input  logic       byp_i,
  input  logic       midspan_i,
  input  logic       det_done_i,
  input  logic       det_valid_i,
  input  logic       cls_done_i,
  input  logic       cls_valid_i,
  input  logic       cls_exp_i,
  input  logic       wait_exp_i,
  output seq_state_e st_o,
  output logic       det_start_o,
  output logic       cls_start_o,
  output logic       det_end_o,
  output logic       cls_end_o,
  output logic       det_ok_o,
  output logic       cls_ok_o,
  output logic       det_clr_o,
  output logic       cls_clr_o,
  output logic       off_clr_o
);
  seq_state_e st_q, st_d;
  logic on_cmd, det_fin, cls_fin, evt_clr;
  logic det_start_q, cls_start_q;
  logic det_end_q, cls_end_q, det_ok_q, cls_ok_q;

  assign on_cmd = pwr_on_i && (mode_i != MODE_SHUT);

  always_comb begin
    st_d      = st_q;
    det_clr_o = 1'b0;
    cls_clr_o = 1'b0;
    off_clr_o = 1'b0;
    if (shut_i) begin
      st_d = ST_IDLE;
    end else if (on_cmd) begin
      st_d = ST_PWR;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (!sw_i) begin
            case (mode_i)
              MODE_AUTO: begin
                if (det_en_i)   st_d = ST_DET;
                else if (byp_i) st_d = cls_en_i ? ST_CLS : ST_PWR;
              end
              MODE_SEMI, MODE_MAN: begin
                if (det_en_i)      st_d = ST_DET;
                else if (cls_en_i) st_d = ST_CLS;
              end
              default: ;
            endcase
          end
        end
        ST_DET: begin
          if (det_done_i) begin
            if (mode_i == MODE_MAN) begin
              det_clr_o = 1'b1;
              st_d      = ST_IDLE;
            end else if (det_valid_i) begin
              if (cls_en_i)                st_d = ST_CLS;
              else if (mode_i == MODE_AUTO) st_d = ST_PWR;
              else                          st_d = ST_IDLE;
            end else begin
              st_d = midspan_i ? ST_WAIT : ST_IDLE;
            end
          end
        end
        ST_CLS: begin
          if (cls_done_i || cls_exp_i) begin
            cls_clr_o = (mode_i == MODE_MAN);
            st_d      = (mode_i == MODE_AUTO) ? ST_PWR : ST_IDLE;
          end
        end
        ST_WAIT: begin
          if (sw_i || wait_exp_i) st_d = ST_IDLE;
        end
        ST_PWR: begin
          if (pwr_off_i) begin
            st_d      = ST_IDLE;
            off_clr_o = (mode_i == MODE_SEMI);
          end else if (drop_i) begin
            st_d = ST_IDLE;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  assign det_fin = (st_q == ST_DET) && det_done_i && !shut_i && !on_cmd;
  assign cls_fin = (st_q == ST_CLS) && (cls_done_i || cls_exp_i) && !shut_i && !on_cmd;
  assign evt_clr = shut_i || ((st_q == ST_PWR) && (st_d != ST_PWR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      det_start_q <= 1'b0;
      cls_start_q <= 1'b0;
    end else begin
      st_q        <= st_d;
      det_start_q <= (st_d == ST_DET) && (st_q != ST_DET);
      cls_start_q <= (st_d == ST_CLS) && (st_q != ST_CLS);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      det_end_q <= 1'b0;
      cls_end_q <= 1'b0;
      det_ok_q  <= 1'b0;
      cls_ok_q  <= 1'b0;
    end else if (evt_clr) begin
      det_end_q <= 1'b0;
      cls_end_q <= 1'b0;
      det_ok_q  <= 1'b0;
      cls_ok_q  <= 1'b0;
    end else begin
      if (det_fin) begin
        det_end_q <= 1'b1;
        det_ok_q  <= det_valid_i;
      end
      if (cls_fin) begin
        cls_end_q <= 1'b1;
        cls_ok_q  <= cls_done_i && cls_valid_i;
      end
    end
  end

  assign st_o        = st_q;
  assign det_start_o = det_start_q;
  assign cls_start_o = cls_start_q;
  assign det_end_o   = det_end_q;
  assign cls_end_o   = cls_end_q;
  assign det_ok_o    = det_ok_q;
  assign cls_ok_o    = cls_ok_q;
endmodule

// File: rtl/poe_port_seq.sv
`timescale 1ns/1ps
module poe_port_seq
  import poe_seq_pkg::*;
#(
  parameter int unsigned CLK_KHZ     = 1000,
  parameter int unsigned CLS_WIN_MS  = 40,
  parameter int unsigned MID_WAIT_MS = 2200
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       en_wr_i,
  input  logic       det_en_d_i,
  input  logic       cls_en_d_i,
  input  logic       pwr_on_i,
  input  logic       pwr_off_i,
  input  logic       drop_i,
  input  logic       det_byp_i,
  input  logic       midspan_i,
  input  logic       det_done_i,
  input  logic       det_valid_i,
  input  logic       cls_done_i,
  input  logic       cls_valid_i,
  output logic [1:0] mode_o,
  output logic       det_en_o,
  output logic       cls_en_o,
  output logic       det_start_o,
  output logic       cls_start_o,
  output logic       gate_en_o,
  output logic       det_end_o,
  output logic       cls_end_o,
  output logic       det_ok_o,
  output logic       cls_ok_o
);
  localparam int unsigned CLS_WIN_CYC  = CLK_KHZ * CLS_WIN_MS;
  localparam int unsigned MID_WAIT_CYC = CLK_KHZ * MID_WAIT_MS;

  port_mode_e req, mode_q;
  seq_state_e st;
  logic shut, enter, busy, powered;
  logic det_en, cls_en, det_clr, cls_clr, off_clr;
  logic cls_exp, wait_exp;

  assign req     = port_mode_e'(mode_i);
  assign busy    = (st == ST_DET) || (st == ST_CLS);
  assign powered = (st == ST_PWR);

  poe_seq_mode u_mode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req),
    .busy_i  (busy),
    .mode_o  (mode_q),
    .shut_o  (shut),
    .enter_o (enter)
  );

  poe_seq_enables u_en (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode_q),
    .new_mode_i (req),
    .enter_i    (enter),
    .shut_i     (shut),
    .powered_i  (powered),
    .wr_i       (en_wr_i),
    .det_d_i    (det_en_d_i),
    .cls_d_i    (cls_en_d_i),
    .det_clr_i  (det_clr),
    .cls_clr_i  (cls_clr),
    .off_clr_i  (off_clr),
    .det_en_o   (det_en),
    .cls_en_o   (cls_en)
  );

  poe_seq_timer #(.LEN(CLS_WIN_CYC)) u_cls_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (st == ST_CLS),
    .exp_o  (cls_exp)
  );

  poe_seq_timer #(.LEN(MID_WAIT_CYC)) u_mid_wait (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (st == ST_WAIT),
    .exp_o  (wait_exp)
  );

  poe_seq_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_q),
    .shut_i      (shut),
    .sw_i        (enter),
    .pwr_on_i    (pwr_on_i),
    .pwr_off_i   (pwr_off_i),
    .drop_i      (drop_i),
    .det_en_i    (det_en),
    .cls_en_i    (cls_en),
    .byp_i       (det_byp_i),
    .midspan_i   (midspan_i),
    .det_done_i  (det_done_i),
    .det_valid_i (det_valid_i),
    .cls_done_i  (cls_done_i),
    .cls_valid_i (cls_valid_i),
    .cls_exp_i   (cls_exp),
    .wait_exp_i  (wait_exp),
    .st_o        (st),
    .det_start_o (det_start_o),
    .cls_start_o (cls_start_o),
    .det_end_o   (det_end_o),
    .cls_end_o   (cls_end_o),
    .det_ok_o    (det_ok_o),
    .cls_ok_o    (cls_ok_o),
    .det_clr_o   (det_clr),
    .cls_clr_o   (cls_clr),
    .off_clr_o   (off_clr)
  );

  assign mode_o    = mode_q;
  assign det_en_o  = det_en;
  assign cls_en_o  = cls_en;
  assign gate_en_o = powered;
endmodule

// File: rtl/poe_port_seq_chk.sv
`timescale 1ns/1ps
module poe_port_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_i,
  input logic       pwr_on_i,
  input logic [1:0] mode_o,
  input logic       gate_en_o,
  input logic       det_start_o,
  input logic       cls_start_o,
  input logic       det_en_o,
  input logic       cls_en_o,
  input logic       det_end_o,
  input logic       cls_end_o,
  input logic       busy_i
);
  AST_SHUT_GATE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b00) |-> !gate_en_o); // R11

  AST_SHUT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00) |=> (!gate_en_o && !det_en_o && !cls_en_o && !det_end_o && !cls_end_o)); // R11

  AST_PWR_ON_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_on_i && mode_i != 2'b00 && mode_o != 2'b00) |=> gate_en_o); // R10

  AST_STARTS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(det_start_o && cls_start_o)); // R8

  AST_SEMI_NO_SELF_PWR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b10 && !gate_en_o && !pwr_on_i) |=> !gate_en_o); // R6

  AST_MODE_WAITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && mode_i != 2'b00) |=> $stable(mode_o)); // R12

  AST_AUTO_ENTRY_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b11 && $past(mode_o) != 2'b11) |-> (det_en_o && cls_en_o)); // R2
endmodule

bind poe_port_seq poe_port_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .pwr_on_i    (pwr_on_i),
  .mode_o      (mode_o),
  .gate_en_o   (gate_en_o),
  .det_start_o (det_start_o),
  .cls_start_o (cls_start_o),
  .det_en_o    (det_en_o),
  .cls_en_o    (cls_en_o),
  .det_end_o   (det_end_o),
  .cls_end_o   (cls_end_o),
  .busy_i      (busy)
);

// File: tb/poe_port_seq_test.sv
`timescale 1ns/1ps
module poe_port_seq_test;
  localparam int unsigned KHZ      = 1;
  localparam int unsigned WIN_MS   = 8;
  localparam int unsigned WAIT_MS  = 20;
  localparam int          CLS_WIN  = KHZ * WIN_MS;
  localparam int          MID_WAIT = KHZ * WAIT_MS;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       en_wr = 0, det_d = 0, cls_d = 0;
  logic       pwr_on = 0, pwr_off = 0, drop = 0, byp = 0, midspan = 0;
  logic       det_done = 0, det_valid = 0, cls_done = 0, cls_valid = 0;
  logic [1:0] mode_o;
  logic       det_en_o, cls_en_o, det_start_o, cls_start_o, gate_en_o;
  logic       det_end_o, cls_end_o, det_ok_o, cls_ok_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  poe_port_seq #(.CLK_KHZ(KHZ), .CLS_WIN_MS(WIN_MS), .MID_WAIT_MS(WAIT_MS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .en_wr_i(en_wr),
    .det_en_d_i(det_d), .cls_en_d_i(cls_d), .pwr_on_i(pwr_on), .pwr_off_i(pwr_off),
    .drop_i(drop), .det_byp_i(byp), .midspan_i(midspan),
    .det_done_i(det_done), .det_valid_i(det_valid),
    .cls_done_i(cls_done), .cls_valid_i(cls_valid),
    .mode_o(mode_o), .det_en_o(det_en_o), .cls_en_o(cls_en_o),
    .det_start_o(det_start_o), .cls_start_o(cls_start_o), .gate_en_o(gate_en_o),
    .det_end_o(det_end_o), .cls_end_o(cls_end_o), .det_ok_o(det_ok_o), .cls_ok_o(cls_ok_o)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_det(output int n);
    n = 0;
    while (!det_start_o && n < 100) begin
      tick();
      n++;
    end
  endtask

  task automatic count_starts(input int cyc, output int cnt);
    cnt = 0;
    for (int i = 0; i < cyc; i++) begin
      tick();
      cnt += int'(det_start_o) + int'(cls_start_o);
    end
  endtask

  task automatic det_reply(input logic v);
    det_done = 1; det_valid = v;
    tick();
    det_done = 0; det_valid = 0;
  endtask

  task automatic cls_reply(input logic v);
    cls_done = 1; cls_valid = v;
    tick();
    cls_done = 0; cls_valid = 0;
  endtask

  task automatic write_en(input logic d, input logic c);
    en_wr = 1; det_d = d; cls_d = c;
    tick();
    en_wr = 0;
  endtask

  task automatic pulse_on();  pwr_on = 1;  tick(); pwr_on = 0;  endtask
  task automatic pulse_off(); pwr_off = 1; tick(); pwr_off = 0; endtask
  task automatic pulse_drop(); drop = 1;   tick(); drop = 0;    endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog (all requirements) act=running exp=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    int cnt;
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1 reset state
    chk(mode_o, 0, "R1 mode");
    chk(gate_en_o, 0, "R1 gate");
    chk(det_en_o | cls_en_o, 0, "R1 enables");
    chk(det_start_o | cls_start_o, 0, "R1 strobes");
    pulse_on();
    chk(gate_en_o, 0, "R11 pwr_on in shutdown");
    write_en(1, 1);
    chk(det_en_o, 0, "R11 write in shutdown");

    // R2 automatic flow
    mode = 2'b11;
    tick();
    chk(mode_o, 3, "R2 mode");
    chk(det_en_o & cls_en_o, 1, "R2 enables set");
    wait_det(n);
    chk(n, 1, "R2 det start");
    det_reply(1);
    chk(cls_start_o, 1, "R2 cls start");
    chk(det_end_o & det_ok_o, 1, "R14 det flags");
    cls_reply(1);
    chk(gate_en_o, 1, "R2 powered");
    chk(cls_ok_o, 1, "R14 cls ok");
    pulse_off();
    chk(gate_en_o, 0, "R14 off gate");
    chk(det_end_o | cls_end_o | det_ok_o | cls_ok_o, 0, "R14 flags cleared");
    wait_det(n);
    chk(n, 1, "R2 redetect");
    // R4 invalid retry, endpoint
    det_reply(0);
    chk(det_end_o, 1, "R14 det end");
    chk(det_ok_o, 0, "R14 det fail");
    wait_det(n);
    chk(n, 1, "R4 retry gap");

    // R12 switch waits for running detection
    mode = 2'b01;
    repeat (3) tick();
    chk(mode_o, 3, "R12 held while busy");
    det_reply(0);
    chk(mode_o, 3, "R12 held at end cycle");
    tick();
    chk(mode_o, 1, "R12 switched");
    chk(det_en_o | cls_en_o, 0, "R8 enables cleared on entry");
    count_starts(3, cnt);
    chk(cnt, 0, "R8 idle in manual");

    // R8 manual one-shot, order
    write_en(1, 1);
    chk(det_en_o & cls_en_o, 1, "R8 enables written");
    wait_det(n);
    chk(n, 1, "R8 det first");
    chk(cls_start_o, 0, "R8 no cls with det");
    det_reply(1);
    chk(det_en_o, 0, "R8 det self-clear");
    chk(cls_en_o, 1, "R8 cls pending");
    tick();
    chk(cls_start_o, 1, "R8 cls second");
    cls_reply(1);
    chk(cls_en_o, 0, "R8 cls self-clear");
    count_starts(5, cnt);
    chk(cnt, 0, "R8 no repeat");
    chk(gate_en_o, 0, "R8 no power");

    // R10 power-on aborts detection
    write_en(1, 0);
    wait_det(n);
    pulse_on();
    chk(gate_en_o, 1, "R10 abort to power");
    det_reply(1);
    chk(gate_en_o, 1, "R10 late done ignored");
    // R9 manual powered ignores writes
    write_en(0, 1);
    chk(det_en_o, 1, "R9 det unchanged");
    chk(cls_en_o, 0, "R9 cls unchanged");
    count_starts(3, cnt);
    chk(cnt, 0, "R9 no task while powered");
    pulse_off();
    chk(gate_en_o, 0, "R9 off");
    wait_det(n);
    det_reply(0);
    tick();

    // R6 semi-automatic
    mode = 2'b10;
    tick(); tick();
    chk(mode_o, 2, "R6 mode");
    chk(det_en_o | cls_en_o, 0, "R6 enables low");
    count_starts(4, cnt);
    chk(cnt, 0, "R6 idle without enables");
    write_en(1, 1);
    wait_det(n);
    chk(n, 1, "R6 det start");
    det_reply(1);
    chk(cls_start_o, 1, "R6 cls start");
    cls_reply(1);
    chk(gate_en_o, 0, "R6 never powers");
    wait_det(n);
    chk(n, 1, "R6 repeats");
    det_reply(1);
    chk(cls_start_o, 1, "R13 cls entered");
    // R13 classification window
    repeat (CLS_WIN - 1) tick();
    chk(cls_ok_o, 1, "R13 before window end");
    tick();
    chk(cls_ok_o, 0, "R13 timeout result");
    chk(cls_end_o, 1, "R13 timeout end");
    chk(gate_en_o, 0, "R6 no power after cls");
    // R7 drop vs power-off
    pulse_on();
    chk(gate_en_o, 1, "R10 semi power-on");
    pulse_drop();
    chk(gate_en_o, 0, "R7 drop");
    chk(det_en_o & cls_en_o, 1, "R7 drop keeps enables");
    chk(det_end_o, 0, "R14 flags cleared on drop");
    pulse_on();
    chk(gate_en_o, 1, "R10 semi power-on again");
    pulse_off();
    chk(gate_en_o, 0, "R7 off");
    chk(det_en_o | cls_en_o, 0, "R7 off clears enables");
    count_starts(3, cnt);
    chk(cnt, 0, "R7 idle after off");

    // R3 automatic with detection disabled
    mode = 2'b11;
    tick();
    chk(det_en_o & cls_en_o, 1, "R2 enables set again");
    wait_det(n);
    en_wr = 1; det_d = 0; cls_d = 0;
    det_reply(0);
    en_wr = 0;
    chk(det_en_o, 0, "R3 det disabled");
    count_starts(5, cnt);
    chk(cnt, 0, "R3 no strobes");
    chk(gate_en_o, 0, "R3 no power");
    byp = 1;
    tick();
    chk(gate_en_o, 1, "R3 bypass powers");
    byp = 0;

    // R5 midspan back-off
    midspan = 1;
    write_en(1, 1);
    pulse_off();
    wait_det(n);
    chk(n, 1, "R5 first detection immediate");
    det_reply(0);
    wait_det(n);
    chk(n, MID_WAIT + 1, "R5 back-off length");
    det_reply(1);
    cls_reply(1);
    chk(gate_en_o, 1, "R5 powered after retry");
    chk(det_ok_o & cls_ok_o & det_end_o & cls_end_o, 1, "R14 flags while powered");

    // R11 shutdown
    mode = 2'b00;
    tick();
    chk(gate_en_o, 0, "R11 gate off");
    chk(mode_o, 0, "R11 mode");
    chk(det_en_o | cls_en_o, 0, "R11 enables");
    chk(det_end_o | cls_end_o | det_ok_o | cls_ok_o, 0, "R11 flags");
    pulse_on();
    chk(gate_en_o, 0, "R11 pwr_on ignored");
    write_en(1, 1);
    chk(det_en_o | cls_en_o, 0, "R11 write ignored");
    count_starts(3, cnt);
    chk(cnt, 0, "R11 no strobes");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule